// File: doc/BRIEF.md
# I/O Page Table Walker

This block turns an I/O virtual address into a physical address. It walks a radix page table kept in memory. Each table occupies 4 KiB and holds 512 entries of 64 bits, so each level of the walk uses nine bits of the virtual address. The walk starts at a table base supplied with the request. It runs through four levels for a 48-bit input space or five levels for a 57-bit input space. At each level it reads one entry through a simple read port, then either descends to the next table or stops at a leaf.

Entries carry no dedicated valid flag. An entry is present only when its read or write permission bit is set. A leaf is marked by the page-size bit, which is honoured only at levels 1 and 2, giving 2 MiB and 1 GiB pages. Level 0 entries are always leaves. The bit has no meaning at levels 3 and 4. Permissions are combined along the whole path. The consumer receives a physical address with the effective permissions, a not-present fault, or a permission fault. The result stays on the port until the consumer acknowledges it.

Top module: `iopt_walker`

## Requirements
- R1: A request is taken only while `req_ready` is high, which is only while no walk is running and no result is waiting. A `req_valid` raised at any other time has no effect on the result being produced.
- R2: If a virtual address has a non-zero bit at position 48 or above (4-level walk) or at position 57 or above (5-level walk), the request ends with a not-present fault (status 1) and no memory read is made.
- R3: The entry for level L is read at the table base plus eight times the nine-bit index taken from virtual-address bits starting at 12+9L. The first base is `req_root` with its low 12 bits cleared. Every later base is entry bits 51:12 shifted left by 12.
- R4: At most one memory read is outstanding. `mem_req_valid` is a one-cycle pulse, and the walker issues no new read until `mem_rsp_valid` has returned the entry.
- R5: Entry bit 0 is read permission and bit 1 is write permission. An entry with both clear, including an all-zero entry, ends the walk with a not-present fault (status 1), at any level.
- R6: A present entry at level 0 is a leaf. A present entry at level 1 or 2 is a leaf when bit 7 is set. Otherwise it is a pointer to the next table.
- R7: Bit 7 is ignored at levels 3 and 4; entries there are always table pointers.
- R8: On success (status 0), `rsp_pa` equals entry bits 51:12 shifted left by 12, with its low 12+9L bits replaced by the same virtual-address bits, where L is the leaf level.
- R9: The effective read right is the AND of bit 0 over every entry on the path. The effective write right is the AND of bit 1 over the same entries. A read without the read right, or a write without the write right, gives a permission fault (status 2). On success, `rsp_perm` is {leaf bit 2, effective write, effective read}. On any fault, `rsp_pa` and `rsp_perm` are zero.
- R10: `rsp_valid` and the result values stay unchanged until `rsp_ack`. In the cycle after the acknowledge, the walker is idle and `req_ready` is high.
- R11: `req_five_level` = 0 starts the walk at level 3. `req_five_level` = 1 starts it at level 4. A walk that ends at leaf level L therefore makes top−L+1 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_va | input | 64 | Virtual address to translate |
| req_root | input | 52 | Base address of the top-level table |
| req_five_level | input | 1 | 1 = five-level walk, 0 = four-level walk |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | One-cycle entry read pulse |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Result available |
| rsp_ack | input | 1 | Consumer takes the result |
| rsp_status | output | 2 | 0 ok, 1 not present, 2 permission fault |
| rsp_pa | output | 52 | Translated physical address |
| rsp_perm | output | 3 | {execute, write, read} effective rights |

## Verification
Two checks can fall on the same returned entry: the leaf decision and the permission check. A leaf whose rights forbid the access has to become a permission fault, while an entry with neither right has to become a not-present fault whatever its page-size bit says. The bench sweeps every leaf level, both walk depths, both access types and all four read/write combinations on the leaf. It also restricts rights on the intermediate entries, so a fault decided at the leaf depends on bits read several cycles earlier. Each outcome, its address and its rights are compared with values computed arithmetically from the entry fields, and the number of reads is checked to confirm at which level the walk stopped.

// File: rtl/iopt_walker.sv
module iopt_walker #(
  parameter int VA_W = 64,
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic [PA_W-1:0] req_root,
  input  logic            req_five_level,
  input  logic            req_write,
  output logic            mem_req_valid,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ack,
  output logic [1:0]      rsp_status,
  output logic [PA_W-1:0] rsp_pa,
  output logic [2:0]      rsp_perm
);
  localparam int PG = 12;
  localparam int SH = 9;
  localparam int IN4 = PG + 4 * SH;
  localparam int IN5 = PG + 5 * SH;
  localparam logic [1:0] ST_OK = 2'd0, ST_NP = 2'd1, ST_PERM = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} st_t;

  st_t             st_q;
  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] base_q, pa_q;
  logic [2:0]      lvl_q, perm_q;
  logic            wr_q, r_acc, w_acc;
  logic [1:0]      status_q;

  logic [8:0]      idx;
  logic            va_bad, e_present, e_leaf, eff_r, eff_w, allowed;
  logic [PA_W-1:0] e_addr, lo_mask, leaf_pa;
  logic            unused_bits;

  assign va_bad    = (req_va >> (req_five_level ? IN5 : IN4)) != '0;
  assign idx       = 9'(va_q >> (PG + SH * 32'(lvl_q)));
  assign e_present = mem_rsp_data[0] | mem_rsp_data[1];
  assign e_leaf    = (lvl_q == 3'd0) || (lvl_q <= 3'd2 && mem_rsp_data[7]);
  assign eff_r     = r_acc & mem_rsp_data[0];
  assign eff_w     = w_acc & mem_rsp_data[1];
  assign allowed   = wr_q ? eff_w : eff_r;
  assign e_addr    = {mem_rsp_data[PA_W-1:PG], {PG{1'b0}}};
  assign lo_mask   = (PA_W'(1) << (PG + SH * 32'(lvl_q))) - PA_W'(1);
  assign leaf_pa   = (e_addr & ~lo_mask) | (va_q[PA_W-1:0] & lo_mask);
  assign unused_bits = ^{mem_rsp_data[63:PA_W], mem_rsp_data[11:8],
                         mem_rsp_data[6:3], req_root[PG-1:0]};

  assign req_ready     = st_q == S_IDLE;
  assign mem_req_valid = st_q == S_FETCH;
  assign mem_req_addr  = base_q + (PA_W'(idx) << 3);
  assign rsp_valid     = st_q == S_DONE;
  assign rsp_status    = status_q;
  assign rsp_pa        = pa_q;
  assign rsp_perm      = perm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      va_q     <= '0;
      base_q   <= '0;
      lvl_q    <= '0;
      wr_q     <= 1'b0;
      r_acc    <= 1'b0;
      w_acc    <= 1'b0;
      status_q <= ST_OK;
      pa_q     <= '0;
      perm_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          base_q <= {req_root[PA_W-1:PG], {PG{1'b0}}};
          lvl_q  <= req_five_level ? 3'd4 : 3'd3;
          r_acc  <= 1'b1;
          w_acc  <= 1'b1;
          pa_q   <= '0;
          perm_q <= '0;
          if (va_bad) begin
            status_q <= ST_NP;
            st_q     <= S_DONE;
          end else begin
            st_q <= S_FETCH;
          end
        end
        S_FETCH: st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!e_present) begin
            status_q <= ST_NP;
            st_q     <= S_DONE;
          end else if (e_leaf) begin
            st_q <= S_DONE;
            if (allowed) begin
              status_q <= ST_OK;
              pa_q     <= leaf_pa;
              perm_q   <= {mem_rsp_data[2], eff_w, eff_r};
            end else begin
              status_q <= ST_PERM;
            end
          end else begin
            base_q <= e_addr;
            lvl_q  <= lvl_q - 3'd1;
            r_acc  <= eff_r;
            w_acc  <= eff_w;
            st_q   <= S_FETCH;
          end
        end
        default: if (rsp_ack) st_q <= S_IDLE;
      endcase
    end
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R4
  AST_WAIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && !mem_rsp_valid) |=> !mem_req_valid && !rsp_valid); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_status) && $stable(rsp_perm)); // R10
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ack) |=> req_ready && !rsp_valid); // R10
  AST_RANGE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && va_bad) |=> rsp_valid && rsp_status == ST_NP && !mem_req_valid); // R2
  AST_LEAF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_OK) |-> lvl_q <= 3'd2); // R7
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != ST_OK) |-> rsp_pa == '0 && rsp_perm == '0); // R9
endmodule

// File: tb/iopt_walker_bench.sv
module iopt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_five_level = 1'b0, req_write = 1'b0;
  logic [63:0] req_va = '0;
  logic [51:0] req_root = '0;
  logic        mem_rsp_valid = 1'b0, rsp_ack = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        req_ready, mem_req_valid, rsp_valid;
  logic [51:0] mem_req_addr, rsp_pa;
  logic [1:0]  rsp_status;
  logic [2:0]  rsp_perm;

  int tests = 0, fails = 0, nreads = 0, lat = 1;
  logic [63:0] mem [longint];
  bit          pend = 1'b0;
  int          cnt = 0;
  logic [51:0] paddr = '0;

  iopt_walker u_iopt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_root(req_root), .req_five_level(req_five_level),
    .req_write(req_write), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_status(rsp_status), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(longint'(paddr)) ? mem[longint'(paddr)] : 64'd0;
        pend = 1'b0;
      end else cnt--;
    end
    if (mem_req_valid) begin
      pend = 1'b1; paddr = mem_req_addr; cnt = lat - 1; nreads++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [51:0] tbl(input int lv);
    return 52'h10000 * 52'(lv + 1);
  endfunction

  function automatic logic [51:0] eaddr(input logic [51:0] base, input logic [63:0] va, input int lv);
    return base + 52'(((va >> (12 + 9 * lv)) & 64'h1FF) * 8);
  endfunction

  logic [1:0]  g_st;
  logic [51:0] g_pa;
  logic [2:0]  g_perm;

  task automatic walk(input logic [63:0] va, input bit five, input bit wr, input int hold);
    @(negedge clk);
    req_va = va; req_root = tbl(five ? 4 : 3) | 52'h0AB; req_five_level = five;
    req_write = wr; nreads = 0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !rsp_valid; i++) begin
      if (i > 0 || hold > 0) begin
        check(!req_ready, "R1 busy", 64'(req_ready), 64'd0);
        if (hold > 0) begin req_valid = 1'b1; req_va = ~va; end
      end
      @(negedge clk);
    end
    g_st = rsp_status; g_pa = rsp_pa; g_perm = rsp_perm;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && rsp_status == g_st && rsp_pa == g_pa && rsp_perm == g_perm && !req_ready,
            "R10 held", 64'(rsp_pa), 64'(g_pa));
    end
    req_valid = 1'b0;
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    check(req_ready && !rsp_valid, "R10 idle after ack", 64'({req_ready, rsp_valid}), 64'h2);
  endtask

  task automatic run_case(input logic [63:0] va, input bit five, input bit wr, input int leaf,
                          input logic [2:0] lperm, input logic [1:0] mid, input bit ps_high,
                          input logic [39:0] frame, input int hold);
    int top = five ? 4 : 3;
    logic [1:0]  es;
    logic [51:0] mask, epa;
    logic [2:0]  eperm;
    int ereads;
    bit er, ew;
    mem.delete();
    for (int lv = top; lv > leaf; lv--)
      mem[longint'(eaddr(tbl(lv), va, lv))] = 64'(tbl(lv - 1)) | 64'(mid) |
                                              ((ps_high && lv >= 3) ? 64'h80 : 64'h0);
    mem[longint'(eaddr(tbl(leaf), va, leaf))] = (64'(frame) << 12) | 64'(lperm) |
                                                (leaf > 0 ? 64'h80 : 64'h0);
    er = mid[0] & lperm[0];
    ew = mid[1] & lperm[1];
    mask = (52'd1 << (12 + 9 * leaf)) - 52'd1;
    epa = 52'd0; eperm = 3'd0;
    if (mid == 2'd0) begin es = 2'd1; ereads = 1; end
    else begin
      ereads = top - leaf + 1;
      if (lperm[1:0] == 2'd0) es = 2'd1;
      else if (wr ? !ew : !er) es = 2'd2;
      else begin
        es = 2'd0;
        epa = (({frame, 12'd0}) & ~mask) | (va[51:0] & mask);
        eperm = {lperm[2], ew, er};
      end
    end
    walk(va, five, wr, hold);
    check(g_st == es, "R5 R6 R9 status", 64'(g_st), 64'(es));
    check(g_pa == epa, "R8 address", 64'(g_pa), 64'(epa));
    check(g_perm == eperm, "R9 rights", 64'(g_perm), 64'(eperm));
    check(nreads == ereads, "R3 R11 read count", 64'(nreads), 64'(ereads));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] va;
    logic [2:0] lp;
    int k = 0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
          64'({req_ready, rsp_valid, mem_req_valid}), 64'h4);
    rst_n = 1'b1;
    for (int five = 0; five < 2; five++)
      for (int leaf = 0; leaf < 3; leaf++)
        for (int wr = 0; wr < 2; wr++)
          for (int p = 0; p < 4; p++)
            for (int s = 0; s < 3; s++) begin
              k++;
              va = (64'(k) * 64'h9E37_79B9_7F4A_7C15) & (five ? 64'h01FF_FFFF_FFFF_FFFF : 64'h0000_FFFF_FFFF_FFFF);
              lp = {1'(s & 1), 2'(p)};
              lat = (k % 3) + 1;
              run_case(va, five[0], wr[0], leaf, lp, 2'b11, 1'b0, 40'hA5_0000_0000 | 40'(k * 4099), 0);
            end
    // R9: rights on intermediate entries restrict the leaf
    run_case(64'h0000_1234_5678_9ABC, 1'b0, 1'b1, 0, 3'b011, 2'b01, 1'b0, 40'h777, 0);
    run_case(64'h0000_1234_5678_9ABC, 1'b0, 1'b0, 1, 3'b111, 2'b10, 1'b0, 40'h777, 0);
    run_case(64'h0000_1234_5678_9ABC, 1'b1, 1'b0, 2, 3'b011, 2'b01, 1'b0, 40'h777, 0);
    // R5: intermediate entry without rights
    run_case(64'h0000_0ABC_DEF0_1234, 1'b0, 1'b0, 0, 3'b011, 2'b00, 1'b0, 40'h55, 0);
    // R7: page-size bit on levels 3 and 4 ignored
    run_case(64'h00F0_1234_5678_9ABC, 1'b1, 1'b0, 0, 3'b001, 2'b11, 1'b1, 40'h9_9999, 0);
    run_case(64'h0000_1234_5678_9ABC, 1'b0, 1'b1, 2, 3'b010, 2'b11, 1'b1, 40'h9_9999, 0);
    // R5: empty table
    mem.delete();
    walk(64'h0000_0000_0040_0000, 1'b0, 1'b0, 0);
    check(g_st == 2'd1 && nreads == 1, "R5 empty entry", 64'({g_st, 8'(nreads)}), 64'h101);
    // R1 R10: request held high during walk and result held before ack
    run_case(64'h0000_4321_8765_0FED, 1'b0, 1'b0, 1, 3'b101, 2'b11, 1'b0, 40'h3_3000, 4);
    // R2: out-of-range addresses
    walk(64'h0001_0000_0000_0000, 1'b0, 1'b0, 0);
    check(g_st == 2'd1 && nreads == 0, "R2 bit 48 four-level", 64'({g_st, 8'(nreads)}), 64'h100);
    walk(64'h0200_0000_0000_0000, 1'b1, 1'b1, 0);
    check(g_st == 2'd1 && nreads == 0, "R2 bit 57 five-level", 64'({g_st, 8'(nreads)}), 64'h100);
    walk(64'h8000_0000_0000_0000, 1'b1, 1'b0, 0);
    check(g_st == 2'd1 && nreads == 0, "R2 bit 63", 64'({g_st, 8'(nreads)}), 64'h100);
    // R11: bit 48 is legal in a five-level walk
    run_case(64'h0001_0000_0020_3000, 1'b1, 1'b0, 0, 3'b001, 2'b11, 1'b0, 40'h4_4444, 0);
    // R4: no read overlaps a long response latency
    lat = 6;
    run_case(64'h0000_7777_1111_2222, 1'b1, 1'b0, 0, 3'b011, 2'b11, 1'b0, 40'h1_2345, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule